// File: doc/BRIEF.md
# Split Instruction/Data Page Translator

This block turns a 16-bit virtual address into a 22-bit physical address. It keeps two separate banks of eight page entries. One bank serves instruction fetches and the other serves data reads and writes. A single virtual address can therefore land on unrelated physical memory depending on the kind of access. Code and data are kept apart by this choice of bank alone; there is no execute-permission bit.

Each page entry holds three things:
- a relocation base counted in 64-byte units;
- a valid-length limit with 64-byte granularity;
- a valid flag and a write-enable flag.

Each request either produces a physical address or is aborted with a reason code. Page entries are loaded through a small register-write port that stands in for I/O-space stores. A mode input sends data accesses through the instruction bank when separation is turned off.

A request is captured on a clock edge. The physical address, or the abort, is presented combinationally during the cycle that follows.

Top module: `pgx_split_mmu`

## Requirements
- R1: After reset every page entry in both banks is cleared (invalid, zero base, zero length, no write enable), and pa_valid and abort are low.
- R2: A request sampled with req_valid high at a rising edge produces exactly one cycle of either pa_valid or abort right after that edge. In a cycle following an edge without a request, both outputs are low.
- R3: The page number is req_va[15:13] and the offset is req_va[12:0]. For an accepted access, pa = ({base, 6'b0} + offset) modulo 2^22.
- R4: When split_en = 1, fetches (req_kind = 0) use the instruction bank, and reads (req_kind = 1) and writes (req_kind = 2) use the data bank.
- R5: When split_en = 0, reads and writes also use the instruction bank.
- R6: An access to a page whose valid flag is clear aborts with fault_code = 1, and pa_valid stays low.
- R7: The block number is offset[12:6]. If it is greater than the page's length field, the access aborts with fault_code = 2. A block number equal to the length field is accepted.
- R8: A write to a page without write enable aborts with fault_code = 3. Reads and fetches are not affected by the write-enable flag.
- R9: When more than one fault applies, the priority is invalid (1) over length (2) over write (3).
- R10: Config write map:
  - cfg_addr[4] chooses the bank (0 instruction, 1 data).
  - cfg_addr[3] chooses the field (0 base, 1 control).
  - cfg_addr[2:0] chooses the page.
  - The control word is: [6:0] length, [7] valid, [8] write enable.
  - A new value applies to every request sampled at or after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Page entry write strobe |
| cfg_addr | input | 5 | Bank, field and page select |
| cfg_wdata | input | 16 | Base value or control word |
| split_en | input | 1 | 1: data uses data bank; 0: all use instruction bank |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| req_va | input | 16 | Virtual address |
| pa_valid | output | 1 | Physical address is valid |
| pa | output | 22 | Physical address |
| abort | output | 1 | Access refused |
| fault_code | output | 2 | 0 none, 1 invalid, 2 length, 3 write |

## Verification
The same virtual address is sent as a fetch, a read and a write with separation on and off. This shows which bank each kind of access reaches, because the two banks are given distinct bases.

Offsets at and just past a short length limit separate the accepted edge from the length fault. Pages that break several rules at once expose the order of fault priority. A maximum base with the maximum offset exercises the 22-bit wraparound. Rewriting a base between two fetches shows that an update applies to the next request.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_INVALID = 2'd1,
      FLT_LENGTH  = 2'd2,
      FLT_WRITE   = 2'd3
   } fault_e;
endpackage

// File: rtl/pgx_page_bank.sv
module pgx_page_bank #(
   parameter int NPAGES  = 8,
   parameter int RELOC_W = 16,
   parameter int LEN_W   = 7,
   localparam int PG_W   = $clog2(NPAGES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_base,
   input  logic                             we_ctrl,
   input  logic [PG_W-1:0]                  page,
   input  logic [RELOC_W-1:0]               wdata,
   output logic [NPAGES-1:0][RELOC_W-1:0]   base_o,
   output logic [NPAGES-1:0][LEN_W-1:0]     len_o,
   output logic [NPAGES-1:0]                valid_o,
   output logic [NPAGES-1:0]                wen_o
);
   localparam int VLD_BIT = LEN_W;
   localparam int WEN_BIT = LEN_W + 1;

   if (WEN_BIT >= RELOC_W) begin : g_bad_ctrl
      $error("control word does not fit in write data");
   end

   for (genvar p = 0; p < NPAGES; p++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[p]  <= '0;
            len_o[p]   <= '0;
            valid_o[p] <= 1'b0;
            wen_o[p]   <= 1'b0;
         end else if (page == PG_W'(p)) begin
            if (we_base) base_o[p] <= wdata;
            if (we_ctrl) begin
               len_o[p]   <= wdata[LEN_W-1:0];
               valid_o[p] <= wdata[VLD_BIT];
               wen_o[p]   <= wdata[WEN_BIT];
            end
         end
      end
   end

   // R10
   base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_base |=> base_o[$past(page)] == $past(wdata));

   // R10
   ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_ctrl |=> (len_o[$past(page)] == $past(wdata[LEN_W-1:0]))
                  && (valid_o[$past(page)] == $past(wdata[VLD_BIT])));
endmodule

// File: rtl/pgx_xlate_core.sv
module pgx_xlate_core
   import pgx_pkg::*;
#(
   parameter int VA_W      = 16,
   parameter int PAGE_BITS = 3,
   parameter int GRAN_BITS = 6,
   parameter int RELOC_W   = 16,
   localparam int NPAGES   = 1 << PAGE_BITS,
   localparam int OFF_W    = VA_W - PAGE_BITS,
   localparam int LEN_W    = OFF_W - GRAN_BITS,
   localparam int PA_W     = RELOC_W + GRAN_BITS
) (
   input  logic                            active,
   input  acc_kind_e                       kind,
   input  logic                            split,
   input  logic [VA_W-1:0]                 va,
   input  logic [1:0][NPAGES-1:0][RELOC_W-1:0] base_s,
   input  logic [1:0][NPAGES-1:0][LEN_W-1:0]   len_s,
   input  logic [1:0][NPAGES-1:0]          valid_s,
   input  logic [1:0][NPAGES-1:0]          wen_s,
   output logic                            pa_valid,
   output logic [PA_W-1:0]                 pa,
   output logic                            abort,
   output fault_e                          fault
);
   logic [PAGE_BITS-1:0] pg;
   logic [OFF_W-1:0]     off;
   logic [LEN_W-1:0]     blk;
   logic                 bank;
   logic [RELOC_W-1:0]   e_base;
   logic [LEN_W-1:0]     e_len;
   logic                 e_valid, e_wen;

   always_comb begin
      pg      = va[VA_W-1 -: PAGE_BITS];
      off     = va[OFF_W-1:0];
      blk     = off[OFF_W-1 -: LEN_W];
      bank    = (kind != ACC_FETCH) && split;
      e_base  = base_s[bank][pg];
      e_len   = len_s[bank][pg];
      e_valid = valid_s[bank][pg];
      e_wen   = wen_s[bank][pg];
      pa      = {e_base, {GRAN_BITS{1'b0}}} + PA_W'(off);

      if (!e_valid)                          fault = FLT_INVALID;
      else if (blk > e_len)                  fault = FLT_LENGTH;
      else if (kind == ACC_WRITE && !e_wen)  fault = FLT_WRITE;
      else                                   fault = FLT_NONE;

      abort    = active && (fault != FLT_NONE);
      pa_valid = active && (fault == FLT_NONE);
   end
endmodule

// File: rtl/pgx_split_mmu.sv
module pgx_split_mmu
   import pgx_pkg::*;
#(
   parameter int VA_W      = 16,
   parameter int PAGE_BITS = 3,
   parameter int GRAN_BITS = 6,
   parameter int RELOC_W   = 16,
   localparam int NPAGES   = 1 << PAGE_BITS,
   localparam int OFF_W    = VA_W - PAGE_BITS,
   localparam int LEN_W    = OFF_W - GRAN_BITS,
   localparam int PA_W     = RELOC_W + GRAN_BITS,
   localparam int CFG_AW   = PAGE_BITS + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [RELOC_W-1:0]  cfg_wdata,
   input  logic                split_en,
   input  logic                req_valid,
   input  logic [1:0]          req_kind,
   input  logic [VA_W-1:0]     req_va,
   output logic                pa_valid,
   output logic [PA_W-1:0]     pa,
   output logic                abort,
   output logic [1:0]          fault_code
);
   if (LEN_W < 1) begin : g_bad_geom
      $error("offset must be wider than the granule");
   end

   logic [1:0][NPAGES-1:0][RELOC_W-1:0] base_s;
   logic [1:0][NPAGES-1:0][LEN_W-1:0]   len_s;
   logic [1:0][NPAGES-1:0]              valid_s, wen_s;

   for (genvar s = 0; s < 2; s++) begin : g_bank
      logic hit;
      assign hit = cfg_we && (cfg_addr[CFG_AW-1] == 1'(s));
      pgx_page_bank #(.NPAGES(NPAGES), .RELOC_W(RELOC_W), .LEN_W(LEN_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_base (hit && !cfg_addr[PAGE_BITS]),
         .we_ctrl (hit &&  cfg_addr[PAGE_BITS]),
         .page    (cfg_addr[PAGE_BITS-1:0]),
         .wdata   (cfg_wdata),
         .base_o  (base_s[s]),
         .len_o   (len_s[s]),
         .valid_o (valid_s[s]),
         .wen_o   (wen_s[s])
      );
   end

   logic            rq_v, rq_split;
   acc_kind_e       rq_kind;
   logic [VA_W-1:0] rq_va;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rq_v     <= 1'b0;
         rq_split <= 1'b0;
         rq_kind  <= ACC_FETCH;
         rq_va    <= '0;
      end else begin
         rq_v     <= req_valid;
         rq_split <= split_en;
         rq_kind  <= (req_kind == 2'd3) ? ACC_READ : acc_kind_e'(req_kind);
         rq_va    <= req_va;
      end
   end

   fault_e flt;

   pgx_xlate_core #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .GRAN_BITS(GRAN_BITS),
                    .RELOC_W(RELOC_W)) u_core (
      .active   (rq_v),
      .kind     (rq_kind),
      .split    (rq_split),
      .va       (rq_va),
      .base_s   (base_s),
      .len_s    (len_s),
      .valid_s  (valid_s),
      .wen_s    (wen_s),
      .pa_valid (pa_valid),
      .pa       (pa),
      .abort    (abort),
      .fault    (flt)
   );

   assign fault_code = flt;

   // R2
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> (pa_valid || abort));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> !(pa_valid || abort));

   // R6
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (!pa_valid && fault_code != 2'd0));

   // R8
   write_fault_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && fault_code == 2'd3) |-> $past(req_kind) == 2'd2);

   // R3
   byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pa_valid |-> pa[GRAN_BITS-1:0] == $past(req_va[GRAN_BITS-1:0]));
endmodule

// File: tb/tb_pgx_split_mmu.sv
module tb_pgx_split_mmu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        split_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_va = '0;
   logic        pa_valid, abort;
   logic [21:0] pa;
   logic [1:0]  fault_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pgx_split_mmu dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .split_en(split_en), .req_valid(req_valid),
      .req_kind(req_kind), .req_va(req_va), .pa_valid(pa_valid), .pa(pa),
      .abort(abort), .fault_code(fault_code)
   );

   task automatic check(input string tag, input bit ok, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input bit bank, input bit ctrl, input int page,
                      input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {bank, ctrl, 3'(page)}; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(input logic [1:0] k, input logic [15:0] va, input bit sp);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_va = va; split_en = sp;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_pa(input string tag, input logic [21:0] exp);
      check({tag, " pa_valid"}, pa_valid === 1'b1 && abort === 1'b0,
            {pa_valid, abort}, 2'b10);
      check({tag, " pa"}, pa === exp, pa, exp);
   endtask

   task automatic expect_fault(input string tag, input logic [1:0] code);
      check({tag, " abort"}, abort === 1'b1 && pa_valid === 1'b0,
            {abort, pa_valid}, 2'b10);
      check({tag, " code"}, fault_code === code, fault_code, code);
   endtask

   function automatic logic [21:0] xpa(input logic [15:0] b, input logic [15:0] va);
      return 22'({b, 6'b0} + {9'b0, va[12:0]});
   endfunction

   task automatic t_reset;
      check("R1 idle after reset", !pa_valid && !abort, {pa_valid, abort}, 0);
      access(2'd0, 16'h0000, 1'b1);
      expect_fault("R1 cleared instr page", 2'd1);
      access(2'd1, 16'hE000, 1'b1);
      expect_fault("R1 cleared data page", 2'd1);
   endtask

   task automatic t_banks;
      cfg(0, 0, 2, 16'h0100); cfg(0, 1, 2, 16'h00FF);
      cfg(1, 0, 2, 16'h0800); cfg(1, 1, 2, 16'h01FF);
      access(2'd0, 16'h4123, 1'b1); expect_pa("R4 fetch instr bank", xpa(16'h0100, 16'h4123));
      access(2'd1, 16'h4123, 1'b1); expect_pa("R4 read data bank", xpa(16'h0800, 16'h4123));
      access(2'd2, 16'h4123, 1'b1); expect_pa("R4 write data bank", xpa(16'h0800, 16'h4123));
      access(2'd1, 16'h4123, 1'b0); expect_pa("R5 read unified", xpa(16'h0100, 16'h4123));
      access(2'd2, 16'h4123, 1'b0); expect_fault("R5 R8 write unified no wen", 2'd3);
      access(2'd0, 16'h5FC1, 1'b1); expect_pa("R3 R8 fetch no wen ok", xpa(16'h0100, 16'h5FC1));
   endtask

   task automatic t_length;
      cfg(0, 0, 5, 16'h0010); cfg(0, 1, 5, 16'h0083);
      access(2'd0, 16'hA0FF, 1'b1); expect_pa("R7 block equal limit", xpa(16'h0010, 16'hA0FF));
      access(2'd0, 16'hA100, 1'b1); expect_fault("R7 block past limit", 2'd2);
      access(2'd1, 16'hA100, 1'b0); expect_fault("R7 R5 read past limit", 2'd2);
   endtask

   task automatic t_priority;
      cfg(1, 1, 6, 16'h0000);
      access(2'd2, 16'hC040, 1'b1); expect_fault("R9 invalid over others", 2'd1);
      cfg(1, 1, 7, 16'h0080);
      access(2'd2, 16'hE040, 1'b1); expect_fault("R9 length over write", 2'd2);
      access(2'd2, 16'hE03F, 1'b1); expect_fault("R9 write fault alone", 2'd3);
   endtask

   task automatic t_latency;
      access(2'd0, 16'h4000, 1'b1);
      expect_pa("R2 response cycle", xpa(16'h0100, 16'h4000));
      @(negedge clk);
      check("R2 single cycle", !pa_valid && !abort, {pa_valid, abort}, 0);
   endtask

   task automatic t_wrap_update;
      cfg(0, 0, 7, 16'hFFFF); cfg(0, 1, 7, 16'h007F | 16'h0080);
      access(2'd0, 16'hFFFF, 1'b1); expect_pa("R3 wrap 22 bits", 22'h001FBF);
      cfg(0, 0, 2, 16'h0200);
      access(2'd0, 16'h4123, 1'b1); expect_pa("R10 base update", 22'h008123);
      cfg(0, 1, 2, 16'h0000);
      access(2'd0, 16'h4123, 1'b1); expect_fault("R10 R6 invalidated page", 2'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_banks();
      t_length();
      t_priority();
      t_latency();
      t_wrap_update();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule